// File: doc/BRIEF.md
# FIFO Post-Transform Vertex Cache

This block sits between a stream of vertex indices and a vertex transform unit. Every index it accepts is compared, in one cycle, against all occupied entries of a small fully associative tag store. When the index is already present, the block reports the slot holding that vertex's transformed result, with the hit flag set, and does not call the transform unit. When it is absent, the block writes the index into the oldest slot and raises a transform request carrying the index and that slot. It then waits for the transform unit's completion strobe before it reports the slot with the hit flag clear.

Entries are replaced strictly in arrival order. A write pointer moves on only when a miss occurs, so hits never change which entry leaves next. A vertex that was evicted and is asked for again costs a fresh transform. An index producer can therefore arrange its order so that each vertex is transformed exactly once, as long as it knows the capacity. The capacity, the index width and the counter width are all parameters. Two saturating counters record hits and misses. A synchronous flush empties the store, rewinds the pointer and zeroes both counters.

Top module: `vtx_fifo_cache`

## Requirements
- R1: An accepted index that matches an occupied entry produces, on the clock edge after acceptance, `resValid`=1, `resHit`=1 and `resSlot` equal to that entry's slot, and raises no transform request.
- R2: An accepted index that matches no occupied entry raises `xfReqValid` on the next edge, carrying the index and the slot under the write pointer. It holds both until `xfDone` is sampled high, and on that edge it produces `resValid`=1, `resHit`=0 with the same slot. Slots are allocated in the order 0, 1, …, DEPTH-1 and then wrap to 0.
- R3: Replacement is first-in-first-out, and a hit does not change the eviction order. With DEPTH=15, the sequence 0,1,1,2,2,…,14,14,0 leaves exactly indices 0..14 resident, with 15 misses and 15 hits.
- R4: Feeding 0,15,1,16,…,14,29 after that priming makes 15..29 miss once each and 0..14 hit, and afterwards exactly 15..29 are resident. An evicted index misses again and is transformed again.
- R5: `inReady` is 0 whenever a transform request is outstanding, and 1 otherwise (outside flush).
- R6: `hitCount` and `missCount` count hits and misses and stop at 2^CNT_W-1.
- R7: After reset or a flush, no entry is occupied, both counters read 0, no request is pending, and the next miss is given slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of entries, pointer, counters and pending request |
| inValid | input | 1 | Index offered |
| inIndex | input | IDX_W | Vertex index |
| inReady | output | 1 | Index can be accepted |
| xfReqValid | output | 1 | Transform request outstanding |
| xfReqIndex | output | IDX_W | Index to transform |
| xfReqSlot | output | SLOT_W | Slot the result belongs to |
| xfDone | input | 1 | Transform of the outstanding request is complete |
| resValid | output | 1 | Result strobe |
| resSlot | output | SLOT_W | Slot holding the vertex |
| resHit | output | 1 | 1 if the vertex was already resident |
| hitCount | output | CNT_W | Saturating hit count |
| missCount | output | CNT_W | Saturating miss count |

## Verification
The bench builds the block with the default 15 entries and 16-bit indices, so the two directed sequences of R3 and R4 run exactly as written. It narrows the counters to 5 bits. That way the 30 misses and 30 hits of the directed part, plus a few probes, drive both counters into saturation. The random phase draws indices from a range only a little wider than the capacity, which produces a dense mix of hits, evictions and wrap-around of the write pointer.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_WAIT = 1'b1
  } vcState_t;

  typedef struct packed {
    logic accept;
    logic allocate;
    logic finish;
    logic flushAll;
  } vcStrobes_t;

endpackage

// File: rtl/vc_sat_counter.sv
module vc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clear)                count <= '0;
    else if (inc && count != MAXV) count <= count + 1'b1;
  end
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       inValid,
  input  logic       xfDone,
  input  logic       lookupHit,
  output logic       inReady,
  output logic       xfReqValid,
  output vcStrobes_t strb
);
  vcState_t state;

  always_comb begin
    inReady       = (state == CS_IDLE) && !flush;
    strb.flushAll = flush;
    strb.accept   = inValid && inReady;
    strb.allocate = strb.accept && !lookupHit;
    strb.finish   = (state == CS_WAIT) && xfDone && !flush;
  end

  assign xfReqValid = (state == CS_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            state <= CS_IDLE;
    else if (flush)        state <= CS_IDLE;
    else if (strb.allocate) state <= CS_WAIT;
    else if (strb.finish)  state <= CS_IDLE;
  end
endmodule

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int DEPTH  = 15,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vcStrobes_t        strb,
  input  logic [IDX_W-1:0]  inIndex,
  output logic              lookupHit,
  output logic [IDX_W-1:0]  xfReqIndex,
  output logic [SLOT_W-1:0] xfReqSlot,
  output logic              resValid,
  output logic [SLOT_W-1:0] resSlot,
  output logic              resHit
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

  logic [IDX_W-1:0]  tagStore [DEPTH];
  logic [DEPTH-1:0]  tagValid;
  logic [DEPTH-1:0]  matchVec;
  logic [SLOT_W-1:0] matchSlot;
  logic [SLOT_W-1:0] wrPtr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign matchVec[i] = tagValid[i] && (tagStore[i] == inIndex);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tagStore[i] <= '0;
        tagValid[i] <= 1'b0;
      end else if (strb.flushAll) begin
        tagValid[i] <= 1'b0;
      end else if (strb.allocate && wrPtr == SLOT_W'(i)) begin
        tagStore[i] <= inIndex;
        tagValid[i] <= 1'b1;
      end
    end
  end

  assign lookupHit = |matchVec;

  always_comb begin
    matchSlot = '0;
    for (int i = 0; i < DEPTH; i++)
      if (matchVec[i]) matchSlot = matchSlot | SLOT_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr      <= '0;
      xfReqIndex <= '0;
      xfReqSlot  <= '0;
    end else if (strb.flushAll) begin
      wrPtr <= '0;
    end else if (strb.allocate) begin
      xfReqIndex <= inIndex;
      xfReqSlot  <= wrPtr;
      wrPtr      <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resSlot  <= '0;
      resHit   <= 1'b0;
    end else if (strb.flushAll) begin
      resValid <= 1'b0;
    end else if (strb.accept && lookupHit) begin
      resValid <= 1'b1;
      resSlot  <= matchSlot;
      resHit   <= 1'b1;
    end else if (strb.finish) begin
      resValid <= 1'b1;
      resSlot  <= xfReqSlot;
      resHit   <= 1'b0;
    end else begin
      resValid <= 1'b0;
    end
  end
endmodule

// File: rtl/vtx_fifo_cache.sv
module vtx_fifo_cache
  import vc_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int DEPTH  = 15,
  parameter int CNT_W  = 16,
  parameter int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              inValid,
  input  logic [IDX_W-1:0]  inIndex,
  output logic              inReady,
  output logic              xfReqValid,
  output logic [IDX_W-1:0]  xfReqIndex,
  output logic [SLOT_W-1:0] xfReqSlot,
  input  logic              xfDone,
  output logic              resValid,
  output logic [SLOT_W-1:0] resSlot,
  output logic              resHit,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  vcStrobes_t strb;
  logic       lookupHit;

  vc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .inValid(inValid),
    .xfDone(xfDone), .lookupHit(lookupHit), .inReady(inReady),
    .xfReqValid(xfReqValid), .strb(strb)
  );

  vc_datapath #(.IDX_W(IDX_W), .DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .inIndex(inIndex),
    .lookupHit(lookupHit), .xfReqIndex(xfReqIndex), .xfReqSlot(xfReqSlot),
    .resValid(resValid), .resSlot(resSlot), .resHit(resHit)
  );

  vc_sat_counter #(.W(CNT_W)) u_hitCnt (
    .clk(clk), .rst_n(rst_n), .clear(strb.flushAll),
    .inc(strb.accept && lookupHit), .count(hitCount)
  );

  vc_sat_counter #(.W(CNT_W)) u_missCnt (
    .clk(clk), .rst_n(rst_n), .clear(strb.flushAll),
    .inc(strb.allocate), .count(missCount)
  );
endmodule

// File: rtl/vc_cache_checker.sv
module vc_cache_checker #(
  parameter int IDX_W  = 16,
  parameter int DEPTH  = 15,
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              inValid,
  input logic              inReady,
  input logic              xfReqValid,
  input logic [IDX_W-1:0]  xfReqIndex,
  input logic [SLOT_W-1:0] xfReqSlot,
  input logic              xfDone,
  input logic              resValid,
  input logic [SLOT_W-1:0] resSlot,
  input logic              resHit,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  missCount
);
  localparam logic [CNT_W-1:0] MAXC = '1;

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> (int'(resSlot) < DEPTH));

  assert_req_from_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfReqValid) |-> $past(inValid && inReady));

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfReqValid && !xfDone && !flush) |=> (xfReqValid && $stable(xfReqSlot) && $stable(xfReqIndex)));

  assert_miss_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && !resHit) |-> $past(xfReqValid && xfDone));

  assert_ready_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfReqValid |-> !inReady);

  assert_miss_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(missCount) == MAXC && !$past(flush)) |-> missCount == MAXC);

  assert_hit_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hitCount) == MAXC && !$past(flush)) |-> hitCount == MAXC);

  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (hitCount == '0 && missCount == '0 && !xfReqValid && !resValid));
endmodule

bind vtx_fifo_cache vc_cache_checker #(
  .IDX_W(IDX_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .inValid(inValid), .inReady(inReady),
  .xfReqValid(xfReqValid), .xfReqIndex(xfReqIndex), .xfReqSlot(xfReqSlot),
  .xfDone(xfDone), .resValid(resValid), .resSlot(resSlot), .resHit(resHit),
  .hitCount(hitCount), .missCount(missCount)
);

// File: tb/tb_vtx_fifo_cache.sv
module tb_vtx_fifo_cache;
  localparam int IDX_W  = 16;
  localparam int DEPTH  = 15;
  localparam int CNT_W  = 5;
  localparam int SLOT_W = 4;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic inValid = 1'b0;
  logic [IDX_W-1:0] inIndex = '0;
  logic xfDone = 1'b0;
  logic inReady, xfReqValid, resValid, resHit;
  logic [IDX_W-1:0] xfReqIndex;
  logic [SLOT_W-1:0] xfReqSlot, resSlot;
  logic [CNT_W-1:0] hitCount, missCount;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  int mTag [DEPTH];
  bit mValid [DEPTH];
  int mPtr = 0;
  int mHits = 0;
  int mMiss = 0;

  always #10 clk = ~clk;

  vtx_fifo_cache #(.IDX_W(IDX_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .inValid(inValid), .inIndex(inIndex),
    .inReady(inReady), .xfReqValid(xfReqValid), .xfReqIndex(xfReqIndex),
    .xfReqSlot(xfReqSlot), .xfDone(xfDone), .resValid(resValid), .resSlot(resSlot),
    .resHit(resHit), .hitCount(hitCount), .missCount(missCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mFind(input int idx);
    for (int i = 0; i < DEPTH; i++)
      if (mValid[i] && mTag[i] == idx) return i;
    return -1;
  endfunction

  function automatic int satInc(input int v);
    return (v < MAXC) ? v + 1 : v;
  endfunction

  task automatic mClear();
    for (int i = 0; i < DEPTH; i++) mValid[i] = 0;
    mPtr = 0; mHits = 0; mMiss = 0;
  endtask

  task automatic sendIdx(input int idx, input int delay);
    int slot;
    slot = mFind(idx);
    @(negedge clk);
    check(inReady == 1'b1, "R5 ready idle", int'(inReady), 1);
    inValid = 1'b1;
    inIndex = IDX_W'(idx);
    @(posedge clk); #1;
    if (slot >= 0) begin
      mHits = satInc(mHits);
      check(resValid && resHit, "R1 hit flag", int'({resValid, resHit}), 3);
      check(int'(resSlot) == slot, "R1 hit slot", int'(resSlot), slot);
      check(!xfReqValid, "R1 no request", int'(xfReqValid), 0);
      @(negedge clk); inValid = 1'b0;
    end else begin
      slot = mPtr;
      mTag[slot] = idx; mValid[slot] = 1;
      mPtr = (mPtr == DEPTH - 1) ? 0 : mPtr + 1;
      mMiss = satInc(mMiss);
      check(xfReqValid && !resValid, "R2 request raised", int'({xfReqValid, resValid}), 2);
      check(int'(xfReqIndex) == idx, "R2 request index", int'(xfReqIndex), idx);
      check(int'(xfReqSlot) == slot, "R2 request slot", int'(xfReqSlot), slot);
      check(!inReady, "R5 ready low", int'(inReady), 0);
      @(negedge clk); inValid = 1'b0;
      for (int d = 0; d < delay; d++) begin
        @(posedge clk); #1;
        check(!inReady && xfReqValid && !resValid, "R5 waiting",
              int'({inReady, xfReqValid, resValid}), 2);
        @(negedge clk);
      end
      xfDone = 1'b1;
      @(posedge clk); #1;
      check(resValid && !resHit, "R2 miss result", int'({resValid, resHit}), 2);
      check(int'(resSlot) == slot, "R2 miss slot", int'(resSlot), slot);
      check(!xfReqValid && inReady, "R5 released", int'({xfReqValid, inReady}), 1);
      @(negedge clk); xfDone = 1'b0;
    end
  endtask

  task automatic checkCounts(input string req);
    check(int'(hitCount) == mHits, req, int'(hitCount), mHits);
    check(int'(missCount) == mMiss, req, int'(missCount), mMiss);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish();
    end
  end

  initial begin
    int m0;
    void'($urandom(32'd20240611));
    mClear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R7 reset state
    check(inReady && !xfReqValid && !resValid, "R7 reset outputs",
          int'({inReady, xfReqValid, resValid}), 4);
    check(hitCount == '0 && missCount == '0, "R7 reset counts",
          int'(hitCount) + int'(missCount), 0);

    // R3 priming: 0,1,1,2,2,...,14,14,0
    sendIdx(0, 0);
    for (int k = 1; k < DEPTH; k++) begin
      sendIdx(k, k % 3);
      sendIdx(k, 0);
    end
    sendIdx(0, 0);
    check(int'(missCount) == 15 && int'(hitCount) == 15, "R3 priming counts",
          int'(missCount) * 100 + int'(hitCount), 1515);

    // R4 second row: 0,15,1,16,...,14,29
    for (int k = 0; k < DEPTH; k++) begin
      sendIdx(k, 1);
      sendIdx(k + DEPTH, 2);
    end
    check(int'(missCount) == 30, "R4 each new index missed once", int'(missCount), 30);
    check(int'(hitCount) == 30, "R4 old row hit", int'(hitCount), 30);
    for (int k = DEPTH; k < 2 * DEPTH; k++) sendIdx(k, 0);
    check(int'(hitCount) == MAXC, "R6 hit saturation", int'(hitCount), MAXC);
    // R4 evicted index is transformed again
    m0 = mMiss;
    sendIdx(0, 0);
    check(int'(missCount) == m0 + 1, "R4 refetch after eviction", int'(missCount), m0 + 1);
    sendIdx(1, 0);
    check(int'(missCount) == MAXC, "R6 miss saturation", int'(missCount), MAXC);
    checkCounts("R6 counts");

    // R7 flush
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    mClear();
    checkCounts("R7 flush counts");
    sendIdx(17, 0);
    check(mPtr == 1, "R7 first slot after flush", mPtr, 1);
    sendIdx(17, 0);

    // random phase checked against the FIFO model (R1 R2 R3)
    for (int n = 0; n < 400; n++) begin
      sendIdx(int'($urandom_range(0, 21)), int'($urandom_range(0, 3)));
      if (n % 50 == 49) checkCounts("R6 random counts");
    end
    finish();
  end
endmodule